// File: doc/BRIEF.md
# Combo PHY Power-Up Configuration Sequencer

This block brings a combined USB3/PCIe serial PHY into a usable state after reset without software stepping through each access. A one-cycle `start_i` pulse launches the command on `cmd_i` for the protocol on `mode_i`. The sequencer then writes masked fields of three 32-bit local PHY control registers directly. Where a command needs it, it also runs a fixed, ordered list of read-modify-write updates on the PHY's 16-bit internal control bus through a request/acknowledge command port.

In USB3 mode the initialisation command runs in four phases, in this order:
1. It routes the lane to USB3.
2. It runs five masked bus updates. These tune the transmit path, the receive equaliser overrides, the drive level and the PLL loop.
3. It programs the boost level in local register 2.
4. It programs the loss-of-signal fields in local register 1.

In PCIe mode the block sets the power-state field for power-on or power-off. It can also run a timed reset pulse on `phy_rst_o`, with a hold period and a settle period given in clock cycles.

Progress is reported on three outputs:
- `busy_o` is high while a command is running.
- `done_o` is a one-cycle pulse at the end of every accepted command.
- `error_o` goes high when a bus access is acknowledged with an error. The remaining steps are dropped, and the flag holds until the next accepted start.

Top module: `phy_cfg_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `busy_o`, `done_o`, `error_o`, `cr_req_o` and `phy_rst_o` are 0, and the three local registers hold their parameter reset values.
- R2: In USB3 mode (`mode_i`=0) the init command (`cmd_i`=0) sets local register 0 bits 6:5 to 2'b11 on the first edge after the start edge. Other bits are kept, and this happens before any bus request.
- R3: The init command issues exactly ten bus transfers. They are a read (`cr_we_o`=0) followed by a write (`cr_we_o`=1) to each of 0x102D, 0x1010, 0x1006, 0x1002 and 0x0030, in that order. Each write carries (read data & ~mask) | (value & mask).
- R4: The (mask, value) pairs are: 0x102D (0x0080, 0x0080); 0x1010 (0x0FF0, 20); 0x1006 (0x0FC0, 0x0B80); 0x1002 (0x7FFF, 0x4B7F); 0x0030 (0x00F0, 0x0080). Bit 2 of 0x1010 therefore keeps its old value, because the value is masked.
- R5: After the last bus write, local register 2 bits 20:18 become 4, and local register 1 bits 23:21 become 4 and bits 20:16 become 9. All other bits are kept.
- R6: Once `cr_req_o` rises, it stays high with `cr_addr_o`, `cr_we_o` and `cr_wdata_o` stable until a cycle with `cr_ack_i`=1. Only one transfer is outstanding at a time.
- R7: An acknowledge with `cr_err_i`=1 ends the command. `error_o` and `done_o` are set, no further request is issued, and local registers 1 and 2 are not written.
- R8: In PCIe mode (`mode_i`=1), power-on (`cmd_i`=1) sets local register 0 bits 4:0 to 0x1C and power-off (`cmd_i`=2) sets them to 0x1D. Other bits are kept, no bus transfer is made, and `done_o` rises one edge after the start edge.
- R9: PCIe reset (`cmd_i`=3) drives `phy_rst_o` high from the start edge for exactly `HOLD_CYCLES` cycles. `done_o` rises `SETTLE_CYCLES` cycles after `phy_rst_o` falls.
- R10: A command that does not apply to the mode changes nothing and makes no bus transfer, and `done_o` rises one edge after the start edge. These commands are power-on, power-off and reset in USB3 mode, and init in PCIe mode.
- R11: `start_i` is ignored while `busy_o` is high.
- R12: In USB3 init the first `cr_req_o` rises on the second edge after the start edge. `done_o` rises on the second edge after the edge that takes the final write acknowledge. On a bus error it rises on the first edge after the erroring acknowledge.
- R13: `done_o` lasts one cycle. `error_o` holds until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 0 = USB3, 1 = PCIe |
| cmd_i | input | 2 | 0 init, 1 power-on, 2 power-off, 3 reset |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky bus error flag |
| phy_rst_o | output | 1 | PHY reset output |
| cr_req_o | output | 1 | Control bus request |
| cr_we_o | output | 1 | Control bus write (1) or read (0) |
| cr_addr_o | output | 16 | Control bus address |
| cr_wdata_o | output | 16 | Control bus write data |
| cr_ack_i | input | 1 | Control bus acknowledge, one cycle |
| cr_err_i | input | 1 | Error qualifier on the acknowledge |
| cr_rdata_i | input | 16 | Read data qualified by the acknowledge |
| lreg0_o | output | 32 | Local control register 0 |
| lreg1_o | output | 32 | Local control register 1 |
| lreg2_o | output | 32 | Local control register 2 |

## Verification
Every result is due at a fixed edge relative to a known event:
- The select-field write is due one edge after the start edge.
- The first bus request is due two edges after the start edge.
- Completion is due two edges after the last write acknowledge, or one edge after an erroring acknowledge.
- Non-applicable and power commands complete one edge after the start edge.
- The reset pulse lasts exactly the hold count, and done follows after the settle count.

The bench keeps an edge counter and records the edge of each start and of each acknowledge. It then compares the edge on which each output is first seen against these offsets. Bus transfers are compared in order against a queue of expected items, at the moment they are acknowledged.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int CR_AW     = 16;
  localparam int CR_DW     = 16;
  localparam int LREG_W    = 32;
  localparam int LREG_N    = 3;
  localparam int NUM_STEPS = 5;
  localparam int STEP_IW   = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {
    CMD_INIT    = 2'd0,
    CMD_PWR_ON  = 2'd1,
    CMD_PWR_OFF = 2'd2,
    CMD_RESET   = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [CR_AW-1:0] addr;
    logic [CR_DW-1:0] mask;
    logic [CR_DW-1:0] val;
  } rmw_step_t;

  // local register 0: lane protocol select and power state
  localparam logic [LREG_W-1:0] SEL_MASK    = LREG_W'(32'h3) << 5;
  localparam logic [LREG_W-1:0] SEL_USB3    = LREG_W'(32'h3) << 5;
  localparam logic [LREG_W-1:0] PWR_MASK    = LREG_W'(32'h1F);
  localparam logic [LREG_W-1:0] PWR_ON_VAL  = LREG_W'(32'h1C);
  localparam logic [LREG_W-1:0] PWR_OFF_VAL = LREG_W'(32'h1D);
  // local register 1: loss-of-signal bias (23:21) and level (20:16)
  localparam logic [LREG_W-1:0] LOS_MASK    = LREG_W'(32'hFF) << 16;
  localparam logic [LREG_W-1:0] LOS_VAL     = (LREG_W'(32'd4) << 21) | (LREG_W'(32'd9) << 16);
  // local register 2: transmit boost level (20:18)
  localparam logic [LREG_W-1:0] BOOST_MASK  = LREG_W'(32'h7) << 18;
  localparam logic [LREG_W-1:0] BOOST_VAL   = LREG_W'(32'd4) << 18;

  // ordered bus update list; the order is part of the behaviour
  function automatic rmw_step_t step_entry(input logic [STEP_IW-1:0] idx);
    rmw_step_t s;
    case (idx)
      STEP_IW'(0): s = '{addr: 16'h102D, mask: 16'h0080, val: 16'h0080};
      STEP_IW'(1): s = '{addr: 16'h1010, mask: 16'h0FF0, val: 16'd20};
      STEP_IW'(2): s = '{addr: 16'h1006, mask: 16'h0FC0, val: 16'h0B80};
      STEP_IW'(3): s = '{addr: 16'h1002, mask: 16'h7FFF, val: 16'h4B7F};
      STEP_IW'(4): s = '{addr: 16'h0030, mask: 16'h00F0, val: 16'h0080};
      default:     s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/phy_cfg_lregs.sv
module phy_cfg_lregs #(
  parameter int W = 32,
  parameter int N = 3,
  parameter logic [N-1:0][W-1:0] INIT = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0][W-1:0] wmask_i,
  input  logic [N-1:0][W-1:0] wval_i,
  output logic [N-1:0][W-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_o[g] <= INIT[g];
      end else begin
        q_o[g] <= (q_o[g] & ~wmask_i[g]) | (wval_i[g] & wmask_i[g]);
      end
    end
  end

endmodule

// File: rtl/phy_cfg_timer.sv
module phy_cfg_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic [TW-1:0] limit_i,
  output logic          hit_o
);

  logic [TW-1:0] cnt;

  assign hit_o = en_i && (cnt == limit_i - TW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear_i || hit_o) begin
      cnt <= '0;
    end else if (en_i) begin
      cnt <= cnt + TW'(1);
    end
  end

endmodule

// File: rtl/phy_cfg_rmw.sv
module phy_cfg_rmw #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] val_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic [DW-1:0] rdata_i,
  output logic          done_o,
  output logic          err_o
);

  typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} eng_st_e;

  eng_st_e       st;
  logic [DW-1:0] mask_q;
  logic [DW-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= E_IDLE;
      req_o   <= 1'b0;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      mask_q  <= '0;
      val_q   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go_i) begin
            addr_o  <= addr_i;
            mask_q  <= mask_i;
            val_q   <= val_i & mask_i;
            req_o   <= 1'b1;
            we_o    <= 1'b0;
            wdata_o <= '0;
            st      <= E_RD;
          end
        end
        E_RD: begin
          if (ack_i) begin
            if (err_i) begin
              req_o <= 1'b0;
              err_o <= 1'b1;
              st    <= E_IDLE;
            end else begin
              we_o    <= 1'b1;
              wdata_o <= (rdata_i & ~mask_q) | val_q;
              st      <= E_WR;
            end
          end
        end
        E_WR: begin
          if (ack_i) begin
            req_o  <= 1'b0;
            we_o   <= 1'b0;
            err_o  <= err_i;
            done_o <= !err_i;
            st     <= E_IDLE;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
  import phy_cfg_pkg::*;
#(
  parameter int                HOLD_CYCLES   = 50000,
  parameter int                SETTLE_CYCLES = 50000,
  parameter logic [LREG_W-1:0] LREG0_INIT    = '0,
  parameter logic [LREG_W-1:0] LREG1_INIT    = '0,
  parameter logic [LREG_W-1:0] LREG2_INIT    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [1:0]        cmd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              phy_rst_o,
  output logic              cr_req_o,
  output logic              cr_we_o,
  output logic [CR_AW-1:0]  cr_addr_o,
  output logic [CR_DW-1:0]  cr_wdata_o,
  input  logic              cr_ack_i,
  input  logic              cr_err_i,
  input  logic [CR_DW-1:0]  cr_rdata_i,
  output logic [LREG_W-1:0] lreg0_o,
  output logic [LREG_W-1:0] lreg1_o,
  output logic [LREG_W-1:0] lreg2_o
);

  localparam int MAX_WAIT = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
  localparam int TW       = $clog2(MAX_WAIT + 1);
  localparam logic [STEP_IW-1:0] LAST_STEP = STEP_IW'(NUM_STEPS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SWITCH, S_ISSUE, S_WAIT, S_LOCAL, S_PWR, S_NOP, S_HOLD, S_SETTLE
  } seq_st_e;

  seq_st_e              state;
  cmd_e                 cmd_q;
  logic [STEP_IW-1:0]   step;
  rmw_step_t            cur;
  logic                 eng_done;
  logic                 eng_err;
  logic                 tmr_hit;
  logic                 tmr_en;
  logic [TW-1:0]        tmr_limit;
  logic [LREG_N-1:0][LREG_W-1:0] lw_mask;
  logic [LREG_N-1:0][LREG_W-1:0] lw_val;
  logic [LREG_N-1:0][LREG_W-1:0] lq;

  assign cur = step_entry(step);

  phy_cfg_rmw #(.AW(CR_AW), .DW(CR_DW)) u_rmw (
    .clk     (clk),
    .rst     (rst),
    .go_i    (state == S_ISSUE),
    .addr_i  (cur.addr),
    .mask_i  (cur.mask),
    .val_i   (cur.val),
    .req_o   (cr_req_o),
    .we_o    (cr_we_o),
    .addr_o  (cr_addr_o),
    .wdata_o (cr_wdata_o),
    .ack_i   (cr_ack_i),
    .err_i   (cr_err_i),
    .rdata_i (cr_rdata_i),
    .done_o  (eng_done),
    .err_o   (eng_err)
  );

  assign tmr_en    = (state == S_HOLD) || (state == S_SETTLE);
  assign tmr_limit = (state == S_HOLD) ? TW'(HOLD_CYCLES) : TW'(SETTLE_CYCLES);

  phy_cfg_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear_i (state == S_IDLE),
    .en_i    (tmr_en),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  always_comb begin
    lw_mask = '0;
    lw_val  = '0;
    case (state)
      S_SWITCH: begin
        lw_mask[0] = SEL_MASK;
        lw_val[0]  = SEL_USB3;
      end
      S_PWR: begin
        lw_mask[0] = PWR_MASK;
        lw_val[0]  = (cmd_q == CMD_PWR_ON) ? PWR_ON_VAL : PWR_OFF_VAL;
      end
      S_LOCAL: begin
        lw_mask[2] = BOOST_MASK;
        lw_val[2]  = BOOST_VAL;
        lw_mask[1] = LOS_MASK;
        lw_val[1]  = LOS_VAL;
      end
      default: ;
    endcase
  end

  phy_cfg_lregs #(
    .W    (LREG_W),
    .N    (LREG_N),
    .INIT ({LREG2_INIT, LREG1_INIT, LREG0_INIT})
  ) u_lregs (
    .clk     (clk),
    .rst     (rst),
    .wmask_i (lw_mask),
    .wval_i  (lw_val),
    .q_o     (lq)
  );

  assign lreg0_o = lq[0];
  assign lreg1_o = lq[1];
  assign lreg2_o = lq[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cmd_q     <= CMD_INIT;
      step      <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      error_o   <= 1'b0;
      phy_rst_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            busy_o  <= 1'b1;
            error_o <= 1'b0;
            cmd_q   <= cmd_e'(cmd_i);
            step    <= '0;
            if (!mode_i) begin
              state <= (cmd_e'(cmd_i) == CMD_INIT) ? S_SWITCH : S_NOP;
            end else begin
              case (cmd_e'(cmd_i))
                CMD_PWR_ON, CMD_PWR_OFF: state <= S_PWR;
                CMD_RESET: begin
                  phy_rst_o <= 1'b1;
                  state     <= S_HOLD;
                end
                default: state <= S_NOP;
              endcase
            end
          end
        end
        S_SWITCH: state <= S_ISSUE;
        S_ISSUE:  state <= S_WAIT;
        S_WAIT: begin
          if (eng_err) begin
            error_o <= 1'b1;
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state   <= S_IDLE;
          end else if (eng_done) begin
            if (step == LAST_STEP) begin
              state <= S_LOCAL;
            end else begin
              step  <= step + STEP_IW'(1);
              state <= S_ISSUE;
            end
          end
        end
        S_LOCAL, S_PWR, S_NOP: begin
          done_o <= 1'b1;
          busy_o <= 1'b0;
          state  <= S_IDLE;
        end
        S_HOLD: begin
          if (tmr_hit) begin
            phy_rst_o <= 1'b0;
            state     <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (tmr_hit) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_cfg_seq_chk.sv
module phy_cfg_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy_o,
  input logic        done_o,
  input logic        error_o,
  input logic        phy_rst_o,
  input logic        cr_req_o,
  input logic        cr_we_o,
  input logic [15:0] cr_addr_o,
  input logic [15:0] cr_wdata_o,
  input logic        cr_ack_i,
  input logic        cr_err_i,
  input logic [31:0] lreg0_o
);

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !error_o && !cr_req_o && !phy_rst_o));

  // R2: lane select is already USB3 whenever the bus is used
  a_r2_switch_first: assert property (@(posedge clk) disable iff (rst)
    cr_req_o |-> (lreg0_o[6:5] == 2'b11));

  // R6: request and its payload hold until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    (cr_req_o && !cr_ack_i) |=>
      (cr_req_o && $stable(cr_addr_o) && $stable(cr_we_o) && $stable(cr_wdata_o)));

  // R7: nothing issued after an erroring acknowledge
  a_r7_stop_on_err: assert property (@(posedge clk) disable iff (rst)
    (cr_req_o && cr_ack_i && cr_err_i) |=> !cr_req_o);

  // R9: reset output only during a running command
  a_r9_rst_in_cmd: assert property (@(posedge clk) disable iff (rst)
    phy_rst_o |-> busy_o);

  // R13: done is a single-cycle pulse
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

bind phy_cfg_seq phy_cfg_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .phy_rst_o  (phy_rst_o),
  .cr_req_o   (cr_req_o),
  .cr_we_o    (cr_we_o),
  .cr_addr_o  (cr_addr_o),
  .cr_wdata_o (cr_wdata_o),
  .cr_ack_i   (cr_ack_i),
  .cr_err_i   (cr_err_i),
  .lreg0_o    (lreg0_o)
);

// File: tb/tb_phy_cfg_seq.sv
`timescale 1ns/1ps
module tb_phy_cfg_seq;

  localparam int HOLD   = 40;
  localparam int SETTLE = 25;
  localparam int LAT    = 3;
  localparam logic [31:0] L0I = 32'h0000_0102;
  localparam logic [31:0] L1I = 32'hA5A5_A5A5;
  localparam logic [31:0] L2I = 32'h5A5A_5A5A;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } txn_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic busy, done, error, phy_rst;
  logic cr_req, cr_we;
  logic [15:0] cr_addr, cr_wdata;
  logic cr_ack = 1'b0;
  logic cr_err = 1'b0;
  logic [15:0] cr_rdata = '0;
  logic [31:0] l0, l1, l2;

  always #5 clk = ~clk;

  phy_cfg_seq #(
    .HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETTLE),
    .LREG0_INIT(L0I), .LREG1_INIT(L1I), .LREG2_INIT(L2I)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .cmd_i(cmd),
    .busy_o(busy), .done_o(done), .error_o(error), .phy_rst_o(phy_rst),
    .cr_req_o(cr_req), .cr_we_o(cr_we), .cr_addr_o(cr_addr), .cr_wdata_o(cr_wdata),
    .cr_ack_i(cr_ack), .cr_err_i(cr_err), .cr_rdata_i(cr_rdata),
    .lreg0_o(l0), .lreg1_o(l1), .lreg2_o(l2)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int s_edge = 0;
  int done_edge = 0;
  int last_ack_edge = 0;
  int first_req_cyc = 0;
  int txn_count = 0;
  bit seen_req = 1'b0;
  bit err_en = 1'b0;
  logic [15:0] err_addr = '0;
  logic [15:0] crmem [int];
  txn_t exp_q [$];

  logic [15:0] st_addr [5] = '{16'h102D, 16'h1010, 16'h1006, 16'h1002, 16'h0030};
  logic [15:0] st_mask [5] = '{16'h0080, 16'h0FF0, 16'h0FC0, 16'h7FFF, 16'h00F0};
  logic [15:0] st_val  [5] = '{16'h0080, 16'd20,   16'h0B80, 16'h4B7F, 16'h0080};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_rd(input logic [15:0] a);
    return crmem.exists(int'(a)) ? crmem[int'(a)] : 16'h0000;
  endfunction

  // bus target model and scoreboard monitor
  initial begin
    int lat_cnt = 0;
    bit unstable = 1'b0;
    logic [15:0] h_addr = '0;
    logic [15:0] h_wd = '0;
    logic h_we = 1'b0;
    txn_t e;
    forever begin
      @(negedge clk);
      cr_ack = 1'b0;
      cr_err = 1'b0;
      if (!cr_req) begin
        lat_cnt = 0;
      end else begin
        if (!seen_req) begin
          seen_req = 1'b1;
          first_req_cyc = cyc;
        end
        if (lat_cnt == 0) begin
          h_addr = cr_addr; h_we = cr_we; h_wd = cr_wdata;
        end else if (h_addr != cr_addr || h_we != cr_we || h_wd != cr_wdata) begin
          unstable = 1'b1;
        end
        lat_cnt++;
        if (lat_cnt == LAT) begin
          lat_cnt = 0;
          cr_ack = 1'b1;
          if (!cr_we) begin
            if (err_en && cr_addr == err_addr) cr_err = 1'b1;
            cr_rdata = mem_rd(cr_addr);
          end else begin
            crmem[int'(cr_addr)] = cr_wdata;
          end
          chk(!unstable, "R6 request payload held until ack", {31'd0, unstable}, 32'd0);
          unstable = 1'b0;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected bus transfer", {15'd0, cr_we, cr_addr}, 32'hFFFF_FFFF);
          end else begin
            e = exp_q.pop_front();
            chk(e.we == cr_we && e.addr == cr_addr && (!cr_we || e.data == cr_wdata),
                "R3 bus transfer order/data", {cr_we, cr_addr, cr_wdata[14:0]},
                {e.we, e.addr, e.data[14:0]});
          end
          last_ack_edge = cyc + 1;
          txn_count++;
        end
      end
    end
  end

  // driver: predicts the bus transfers of one init command
  task automatic push_init_expect(input bit use_err, input logic [15:0] eaddr);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] old;
      exp_q.push_back('{we: 1'b0, addr: st_addr[i], data: 16'h0});
      if (use_err && st_addr[i] == eaddr) return;
      old = mem_rd(st_addr[i]);
      exp_q.push_back('{we: 1'b1, addr: st_addr[i],
                        data: (old & ~st_mask[i]) | (st_val[i] & st_mask[i])});
    end
  endtask

  task automatic do_start(input logic m, input logic [1:0] c);
    @(negedge clk);
    mode = m; cmd = c; start = 1'b1;
    s_edge = cyc + 1;
    seen_req = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (done) begin
        done_edge = cyc;
        return;
      end
      @(negedge clk);
    end
    chk(1'b0, "R12 done never seen", 32'd0, 32'd1);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int t0;
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && !error && !cr_req && !phy_rst, "R1 outputs idle after reset",
        {27'd0, busy, done, error, cr_req, phy_rst}, 32'd0);
    chk(l0 == L0I && l1 == L1I && l2 == L2I, "R1 local register reset values", l1, L1I);

    // USB3 init, target holds zeros
    push_init_expect(1'b0, 16'h0);
    t0 = txn_count;
    do_start(1'b0, 2'd0);
    @(negedge clk);
    chk(l0 == 32'h0000_0162, "R2 select field set one edge after start", l0, 32'h0000_0162);
    chk(l1 == L1I && l2 == L2I, "R5 local fields untouched before bus steps", l2, L2I);
    wait_done();
    chk(first_req_cyc == s_edge + 2, "R12 first request edge", first_req_cyc, s_edge + 2);
    chk(done_edge == last_ack_edge + 2, "R12 done after final write ack", done_edge, last_ack_edge + 2);
    chk(txn_count - t0 == 10 && exp_q.size() == 0, "R3 ten transfers", txn_count - t0, 10);
    chk(mem_rd(16'h102D) == 16'h0080, "R4 0x102D result", mem_rd(16'h102D), 16'h0080);
    chk(mem_rd(16'h1010) == 16'h0010, "R4 0x1010 result, bit 2 kept", mem_rd(16'h1010), 16'h0010);
    chk(mem_rd(16'h1006) == 16'h0B80, "R4 0x1006 result", mem_rd(16'h1006), 16'h0B80);
    chk(mem_rd(16'h1002) == 16'h4B7F, "R4 0x1002 result", mem_rd(16'h1002), 16'h4B7F);
    chk(mem_rd(16'h0030) == 16'h0080, "R4 0x0030 result", mem_rd(16'h0030), 16'h0080);
    chk(l1 == 32'hA589_A5A5, "R5 local register 1", l1, 32'hA589_A5A5);
    chk(l2 == 32'h5A52_5A5A, "R5 local register 2", l2, 32'h5A52_5A5A);
    chk(!error, "R7 no error on clean run", {31'd0, error}, 32'd0);
    @(negedge clk);
    chk(!done, "R13 done one cycle", {31'd0, done}, 32'd0);

    // USB3 init, target holds all ones; a start mid-run must be ignored
    for (int i = 0; i < 5; i++) crmem[int'(st_addr[i])] = 16'hFFFF;
    push_init_expect(1'b0, 16'h0);
    t0 = txn_count;
    do_start(1'b0, 2'd0);
    repeat (5) @(negedge clk);
    mode = 1'b1; cmd = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = 1'b0; cmd = 2'd0;
    wait_done();
    chk(l0[4:0] == 5'h02, "R11 start while busy ignored", l0, 32'h0000_0162);
    chk(txn_count - t0 == 10 && exp_q.size() == 0, "R3 ten transfers second pattern", txn_count - t0, 10);
    chk(mem_rd(16'h1010) == 16'hF01F, "R4 0x1010 with ones", mem_rd(16'h1010), 16'hF01F);
    chk(mem_rd(16'h1006) == 16'hFBBF, "R4 0x1006 with ones", mem_rd(16'h1006), 16'hFBBF);
    chk(mem_rd(16'h1002) == 16'hCB7F, "R4 0x1002 with ones", mem_rd(16'h1002), 16'hCB7F);
    chk(mem_rd(16'h0030) == 16'hFF8F, "R4 0x0030 with ones", mem_rd(16'h0030), 16'hFF8F);
    repeat (4) @(negedge clk);
    chk(!busy, "R11 no second command started", {31'd0, busy}, 32'd0);

    // bus error on the third read
    apply_reset();
    @(negedge clk);
    chk(l0 == L0I && l1 == L1I && l2 == L2I, "R1 reset restores local registers", l0, L0I);
    err_en = 1'b1; err_addr = 16'h1006;
    push_init_expect(1'b1, 16'h1006);
    t0 = txn_count;
    do_start(1'b0, 2'd0);
    wait_done();
    chk(error, "R7 error flag set", {31'd0, error}, 32'd1);
    chk(done_edge == last_ack_edge + 1, "R12 done after erroring ack", done_edge, last_ack_edge + 1);
    repeat (10) @(negedge clk);
    chk(txn_count - t0 == 5 && exp_q.size() == 0 && !cr_req, "R7 no transfer after error", txn_count - t0, 5);
    chk(l1 == L1I && l2 == L2I, "R7 local registers 1/2 not written", l1, L1I);
    chk(error, "R13 error holds", {31'd0, error}, 32'd1);
    err_en = 1'b0;

    // PCIe power-on / power-off
    t0 = txn_count;
    do_start(1'b1, 2'd1);
    wait_done();
    chk(done_edge == s_edge + 1, "R8 power-on done edge", done_edge, s_edge + 1);
    chk(l0 == 32'h0000_017C, "R8 power-on field", l0, 32'h0000_017C);
    chk(!error, "R13 error cleared by next start", {31'd0, error}, 32'd0);
    do_start(1'b1, 2'd2);
    wait_done();
    chk(l0 == 32'h0000_017D, "R8 power-off field", l0, 32'h0000_017D);
    chk(txn_count == t0, "R8 no bus transfer", txn_count, t0);

    // PCIe reset pulse
    do_start(1'b1, 2'd3);
    chk(phy_rst, "R9 reset high from start edge", {31'd0, phy_rst}, 32'd1);
    hi = 0;
    for (int i = 0; i < 500 && !done; i++) begin
      if (phy_rst) hi++;
      @(negedge clk);
    end
    done_edge = cyc;
    chk(hi == HOLD, "R9 reset hold length", hi, HOLD);
    chk(done && done_edge == s_edge + HOLD + SETTLE, "R9 done after settle", done_edge, s_edge + HOLD + SETTLE);

    // non-applicable commands
    t0 = txn_count;
    do_start(1'b0, 2'd2);
    wait_done();
    chk(done_edge == s_edge + 1 && l0 == 32'h0000_017D, "R10 USB3 power-off ignored", l0, 32'h0000_017D);
    do_start(1'b0, 2'd3);
    wait_done();
    chk(done_edge == s_edge + 1 && !phy_rst, "R10 USB3 reset ignored", {31'd0, phy_rst}, 32'd0);
    do_start(1'b1, 2'd0);
    wait_done();
    chk(done_edge == s_edge + 1 && l1 == L1I && l2 == L2I, "R10 PCIe init ignored", l1, L1I);
    repeat (5) @(negedge clk);
    chk(txn_count == t0, "R10 no bus transfer", txn_count, t0);

    finish_run();
  end

endmodule